// File: doc/BRIEF.md
# FSK Period Demodulator with Bit Synchronisation

This block turns the digitised comparator output of a frequency-shift-keyed tag reply into a stream of data bits. It measures each carrier cycle as the number of clock cycles between successive rising edges of the comparator signal. It removes a fixed offset from each measurement and adds the newest four corrected periods into a running sum. A decision with hysteresis on that sum then tells the two keying frequencies apart.

Bit timing is taken from the carrier itself, not from the clock. After a restart, a small sequencer first lets the averaging pipeline fill. It then waits for the first carrier edge that decides 1 and aligns a per-edge counter to it. From then on it emits one decision per 16-edge bit cell, near the middle of the cell. A host pulses `restart` before each reply. It reads bits from `bit_data`/`bit_valid` and watches `sync_lost` for a reply that never locks.

The bit output is a valid-only stream with no ready input. The block has no storage to hold a bit, so the consumer must accept every `bit_valid` pulse in the cycle it appears. Pulses are always separated by at least 16 carrier edges.

Top module: `fsk_bit_demod`

## Requirements
- R1: The comparator input passes through a two-flop synchroniser. The period of a rising edge is the number of clock cycles since the previous rising edge, so edges spaced P clocks apart give a period of P.
- R2: Each period is reduced by 85, modulo 256. `avg_sum` is the 8-bit wrapping sum of the newest four corrected periods. It updates only after a rising edge or a restart. The three older history entries are 10 after reset or restart, so `avg_sum` reads 40 then. Steady periods of 96 give 44, 100 gives 60 and 88 gives 12.
- R3: At each edge the decision becomes 1 when the new sum is 34 or more. It becomes 0 when the sum is below 20. Otherwise it keeps its previous value. The held decision is 0 after restart.
- R4: The first 20 rising edges after a restart never lock, whatever they decide.
- R5: After those 20 edges, the first edge whose decision is 1 locks the block, and `synced` goes high. Edges that decide 0 leave it unlocked.
- R6: Once locked, the first `bit_valid` pulse follows the 8th edge after the locking edge. Further pulses follow every 16th edge after that. Each pulse is one cycle long and carries the current decision on `bit_data`. `bit_valid` is never high while `synced` is low.
- R7: `sync_lost` rises if `synced` has not risen within `sync_limit` clock cycles after a restart. It stays high until the next restart. It does not rise if the block locked earlier.
- R8: `restart` clears `synced`, `sync_lost`, the held decision, the edge count and the history. After a restart no bit is emitted until R4 and R5 are met again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| comp_in | input | 1 | Asynchronous comparator output |
| restart | input | 1 | One-cycle pulse that starts a new reception |
| sync_limit | input | 16 | Clock cycles allowed from restart to lock |
| bit_data | output | 1 | Sampled bit value, valid with `bit_valid` |
| bit_valid | output | 1 | One-cycle strobe per recovered bit |
| synced | output | 1 | High while locked to the bit cells |
| sync_lost | output | 1 | Sticky flag: lock not reached in time |
| avg_sum | output | 8 | Current four-period sum, for debug |

## Verification
The main function is tried with steady carriers of 88, 96 and 100 clocks per cycle. These tell apart the bias subtraction and the four-tap sum through distinct `avg_sum` values. A long run of the 1-frequency right after restart separates the settle count from the first-one lock. Counting edges up to the first and second strobe pins the mid-cell sample position. A multi-cell reply mixes the two keying periods with an intermediate period of 91, which falls inside the hysteresis band. It shows that the held decision follows whichever level came before. This tells hysteresis apart from a plain threshold. Restart and timeout runs, with no edges at all and with an early lock, separate the sticky flag from the lock indication.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;
  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_FIRST  = 2'd1,
    ST_LOCK   = 2'd2
  } sync_st_e;
endpackage

// File: rtl/fsk_edge_sync.sv
module fsk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], sig_i};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fsk_period_avg.sv
module fsk_period_avg #(
  parameter int CW    = 8,
  parameter int TAPS  = 4,
  parameter int BIAS  = 85,
  parameter int INIT  = 10,
  parameter int HI_TH = 34,
  parameter int LO_TH = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          rise_i,
  output logic [CW-1:0] sum_o,
  output logic          dec_o,
  output logic          dec_vld_o
);
  localparam int HW = TAPS - 1;
  localparam logic [CW-1:0] BIAS_C = CW'(BIAS);
  localparam logic [CW-1:0] INIT_C = CW'(INIT);
  localparam logic [CW-1:0] SUM0_C = CW'(TAPS * INIT);
  localparam logic [CW-1:0] HI_C   = CW'(HI_TH);
  localparam logic [CW-1:0] LO_C   = CW'(LO_TH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] hist_q [HW];
  logic [CW-1:0] corr;
  logic [CW-1:0] sum_n;

  assign corr = cnt_q - BIAS_C;

  always_comb begin
    sum_n = corr;
    for (int i = 0; i < HW; i++) sum_n = sum_n + hist_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart)  cnt_q <= '0;
    else if (rise_i)        cnt_q <= CW'(1);
    else                    cnt_q <= cnt_q + CW'(1);
  end

  generate
    for (genvar g = 0; g < HW; g++) begin : g_hist
      always_ff @(posedge clk) begin
        if (!rst_n || restart) hist_q[g] <= INIT_C;
        else if (rise_i)       hist_q[g] <= (g == 0) ? corr : hist_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      sum_o     <= SUM0_C;
      dec_o     <= 1'b0;
      dec_vld_o <= 1'b0;
    end else begin
      dec_vld_o <= rise_i;
      if (rise_i) begin
        sum_o <= sum_n;
        if (sum_n >= HI_C)     dec_o <= 1'b1;
        else if (sum_n < LO_C) dec_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsk_bit_sync.sv
module fsk_bit_sync
  import fsk_demod_pkg::*;
#(
  parameter int SETTLE_EDGES = 20,
  parameter int EC_W         = 8,
  parameter int CELL_LOG2    = 4,
  parameter int SAMPLE_POS   = 7,
  parameter int TO_W         = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            dec_vld_i,
  input  logic            dec_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            bit_o,
  output logic            bit_vld_o,
  output logic            synced_o,
  output logic            lost_o
);
  localparam logic [EC_W-1:0]      SETTLE_C = EC_W'(SETTLE_EDGES);
  localparam logic [CELL_LOG2-1:0] POS_C    = CELL_LOG2'(SAMPLE_POS);

  sync_st_e        st_q;
  logic [EC_W-1:0] ecnt_q;
  logic [EC_W-1:0] ecnt_inc;
  logic [TO_W-1:0] tcnt_q;

  assign ecnt_inc = ecnt_q + EC_W'(1);
  assign synced_o = (st_q == ST_LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      st_q      <= ST_SETTLE;
      ecnt_q    <= '0;
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
    end else begin
      bit_vld_o <= 1'b0;
      if (dec_vld_i) begin
        case (st_q)
          ST_SETTLE: begin
            ecnt_q <= ecnt_inc;
            if (ecnt_inc == SETTLE_C) st_q <= ST_FIRST;
          end
          ST_FIRST: begin
            if (dec_i) begin
              st_q   <= ST_LOCK;
              ecnt_q <= '1;
            end
          end
          default: begin
            ecnt_q <= ecnt_inc;
            if (ecnt_inc[CELL_LOG2-1:0] == POS_C) begin
              bit_vld_o <= 1'b1;
              bit_o     <= dec_i;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      tcnt_q <= '0;
      lost_o <= 1'b0;
    end else if (st_q != ST_LOCK && !lost_o) begin
      if (tcnt_q == limit_i) lost_o <= 1'b1;
      else                   tcnt_q <= tcnt_q + TO_W'(1);
    end
  end
endmodule

// File: rtl/fsk_bit_demod.sv
module fsk_bit_demod #(
  parameter int CW           = 8,
  parameter int TAPS         = 4,
  parameter int BIAS         = 85,
  parameter int INIT         = 10,
  parameter int HI_TH        = 34,
  parameter int LO_TH        = 20,
  parameter int SETTLE_EDGES = 20,
  parameter int CELL_LOG2    = 4,
  parameter int SAMPLE_POS   = 7,
  parameter int TO_W         = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            comp_in,
  input  logic            restart,
  input  logic [TO_W-1:0] sync_limit,
  output logic            bit_data,
  output logic            bit_valid,
  output logic            synced,
  output logic            sync_lost,
  output logic [CW-1:0]   avg_sum
);
  logic edge_p;
  logic dec;
  logic dec_vld;

  fsk_edge_sync #(.STAGES(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (comp_in),
    .rise_o (edge_p)
  );

  fsk_period_avg #(
    .CW(CW), .TAPS(TAPS), .BIAS(BIAS), .INIT(INIT), .HI_TH(HI_TH), .LO_TH(LO_TH)
  ) u_avg (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .rise_i    (edge_p),
    .sum_o     (avg_sum),
    .dec_o     (dec),
    .dec_vld_o (dec_vld)
  );

  fsk_bit_sync #(
    .SETTLE_EDGES(SETTLE_EDGES), .EC_W(CW), .CELL_LOG2(CELL_LOG2),
    .SAMPLE_POS(SAMPLE_POS), .TO_W(TO_W)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .dec_vld_i (dec_vld),
    .dec_i     (dec),
    .limit_i   (sync_limit),
    .bit_o     (bit_data),
    .bit_vld_o (bit_valid),
    .synced_o  (synced),
    .lost_o    (sync_lost)
  );
endmodule

// File: rtl/fsk_bit_demod_chk.sv
module fsk_bit_demod_chk #(
  parameter int CW   = 8,
  parameter int SUM0 = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          edge_p,
  input logic          dec_vld,
  input logic          bit_valid,
  input logic          synced,
  input logic          sync_lost,
  input logic [CW-1:0] avg_sum
);
  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> synced); // R6
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!synced && !bit_valid && !sync_lost && avg_sum == CW'(SUM0))); // R8
  AST_LOST_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_lost) |-> !synced); // R7
  AST_SUM_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_p && !restart) |=> $stable(avg_sum)); // R2
  AST_LOCK_ON_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> $past(dec_vld)); // R5
endmodule

bind fsk_bit_demod fsk_bit_demod_chk #(.CW(CW), .SUM0(TAPS * INIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .edge_p    (edge_p),
  .dec_vld   (dec_vld),
  .bit_valid (bit_valid),
  .synced    (synced),
  .sync_lost (sync_lost),
  .avg_sum   (avg_sum)
);

// File: tb/fsk_bit_demod_tb.sv
module fsk_bit_demod_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        comp_in = 1'b0;
  logic        restart = 1'b0;
  logic [15:0] sync_limit = 16'hFFFF;
  logic        bit_data, bit_valid, synced, sync_lost;
  logic [7:0]  avg_sum;

  int n_chk = 0;
  int n_fail = 0;
  int rx_n = 0;
  logic rx [32];
  bit done = 1'b0;

  always #5 clk = ~clk;

  fsk_bit_demod u_dut (
    .clk(clk), .rst_n(rst_n), .comp_in(comp_in), .restart(restart),
    .sync_limit(sync_limit), .bit_data(bit_data), .bit_valid(bit_valid),
    .synced(synced), .sync_lost(sync_lost), .avg_sum(avg_sum)
  );

  always @(negedge clk) begin
    if (rst_n && bit_valid && rx_n < 32) begin
      rx[rx_n] = bit_data;
      rx_n = rx_n + 1;
    end
  end

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // one carrier cycle: rising edge lands p clocks after the previous one
  task automatic carrier(int p);
    comp_in = 1'b0;
    repeat (p - 4) @(negedge clk);
    comp_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_restart();
    comp_in = 1'b0;
    repeat (4) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset sum", avg_sum, 40);
    chk("R8 reset synced", synced, 0);
    chk("R6 reset valid", bit_valid, 0);
    chk("R7 reset lost", sync_lost, 0);
  endtask

  task automatic t_settle_lock();
    do_restart();
    rx_n = 0;
    repeat (20) carrier(96);
    repeat (2) @(negedge clk);
    chk("R4 no lock in settle", synced, 0);
    chk("R1 sum at period 96", avg_sum, 44);
    carrier(96);
    repeat (2) @(negedge clk);
    chk("R5 lock on first one", synced, 1);
    repeat (7) carrier(96);
    chk("R6 no sample before 8th edge", rx_n, 0);
    carrier(96);
    repeat (2) @(negedge clk);
    chk("R6 sample at 8th edge", rx_n, 1);
    chk("R6 sampled value", rx[0], 1);
    repeat (15) carrier(96);
    chk("R6 no sample inside cell", rx_n, 1);
    carrier(96);
    repeat (2) @(negedge clk);
    chk("R6 next sample 16 edges on", rx_n, 2);
    repeat (8) carrier(100);
    chk("R1 sum at period 100", avg_sum, 60);
  endtask

  task automatic t_stream();
    int per [8] = '{96, 91, 88, 91, 96, 88, 96, 96};
    int exp [8] = '{1, 1, 0, 0, 1, 0, 1, 1};
    do_restart();
    rx_n = 0;
    repeat (24) carrier(88);
    repeat (2) @(negedge clk);
    chk("R2 sum at period 88", avg_sum, 12);
    chk("R5 zeros do not lock", synced, 0);
    for (int c = 0; c < 8; c++) repeat (16) carrier(per[c]);
    repeat (2) @(negedge clk);
    chk("R6 bit count", rx_n, 8);
    for (int c = 0; c < 8; c++) chk("R3 R6 stream bit", rx[c], exp[c]);
  endtask

  task automatic t_timeout();
    sync_limit = 16'd300;
    do_restart();
    repeat (250) @(negedge clk);
    chk("R7 not yet lost", sync_lost, 0);
    repeat (100) @(negedge clk);
    chk("R7 lost after limit", sync_lost, 1);
    do_restart();
    @(negedge clk);
    chk("R8 restart clears lost", sync_lost, 0);
    sync_limit = 16'd5000;
    repeat (21) carrier(96);
    repeat (3500) @(negedge clk);
    chk("R7 early lock keeps lost low", sync_lost, 0);
    chk("R5 locked in timeout run", synced, 1);
  endtask

  task automatic t_restart();
    do_restart();
    chk("R8 restart drops lock", synced, 0);
    chk("R8 restart resets sum", avg_sum, 40);
    rx_n = 0;
    repeat (16) carrier(96);
    repeat (2) @(negedge clk);
    chk("R8 no bits after restart", rx_n, 0);
    chk("R4 still settling", synced, 0);
  endtask

  initial begin
    t_reset();
    t_settle_lock();
    t_stream();
    t_timeout();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule